// File: doc/BRIEF.md
# Alarm Match and Interrupt Latch

This block watches a set of live clock/calendar fields and raises an alarm when they agree with a programmed alarm time. Each field has its own compare enable. Clearing the enables of the slower fields gives a repeating alarm: the alarm then fires every minute, every hour or every day, depending on which fields are left in the comparison. The comparison is made only when the per-second tick is high, so one matching second sets the alarm once.

A match sets a sticky alarm flag. When interrupts are enabled, the flag also pulls the active-low interrupt request low. The request is modelled as an open-drain pull-down enable. The flag stays set until the host writes a zero to it. If auto-clear is enabled, a host read of the status address also clears it. A small strobe interface carries the alarm values, the field enable mask and the control bits. The calendar counters and the serial bus are outside this block.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset, `status_o` and `irq_oe_o` are 0, the field enable mask is 0 and both control bits are 0.
- R2: A write with `wr_en_i` high at address k (k < NUM_FIELDS) stores `wr_data_i` as alarm field k. Field k of `time_i` is bits [8k+7:8k]. Address NUM_FIELDS (6) holds the enable mask: bit k enables field k. Address NUM_FIELDS+1 (7) holds control: bit 0 is the interrupt enable and bit 1 is auto-clear. Address NUM_FIELDS+2 (8) is status: bit 0 is the alarm flag.
- R3: The comparison is made only in a cycle with `tick_i` high. Matching fields with `tick_i` low leave `status_o` unchanged.
- R4: On a tick, the flag sets in the next cycle when every enabled field of `time_i` equals its alarm field. Fields whose enable bit is 0 have no effect.
- R5: With an enable mask of 0, a tick never sets the flag.
- R6: The flag sets whatever the interrupt enable holds. `irq_oe_o` is high exactly when the flag and the interrupt enable are both 1.
- R7: Once set, the flag stays set until it is cleared. A write of 0 to status bit 0 clears it. A write of 1 there, or a write to any other address, leaves it set.
- R8: A read strobe (`rd_en_i`) at the status address clears the flag when auto-clear is 1. It has no effect when auto-clear is 0.
- R9: When a match and a clear occur in the same cycle, the flag is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| time_i | input | NUM_FIELDS*FIELD_W | Live time fields, field k at [8k+7:8k] |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address for read or write |
| wr_data_i | input | FIELD_W | Write data |
| status_o | output | 1 | Alarm flag |
| irq_oe_o | output | 1 | Pull-down enable of the active-low interrupt line |

## Verification
The main sweep covers every enable mask against every per-field equality pattern, with a non-matching value placed in each field that is meant to differ. This separates a correct AND over the enabled lanes from an OR, from a missing lane and from an ignored enable bit. The all-zero mask row checks that an empty mask never fires. The interrupt enable is toggled across the sweep, so gating of `irq_oe_o` is checked separately from setting of the flag. Directed sequences then cover matches with no tick, clears that must not clear, reads with and without auto-clear, and a match that lands in the same cycle as a clear.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int unsigned CTRL_IEN_BIT  = 0;
  localparam int unsigned CTRL_AUTO_BIT = 1;
  localparam int unsigned STAT_FLAG_BIT = 0;

  typedef struct packed {
    logic auto_clr;
    logic irq_en;
  } alm_ctrl_t;
endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 6,
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [FIELD_W-1:0]            wr_data_i,
  output logic [NUM_FIELDS*FIELD_W-1:0] alarm_o,
  output logic [NUM_FIELDS-1:0]         mask_o,
  output alm_ctrl_t                     ctrl_o
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_FIELDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS + 1);

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    logic [FIELD_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  val_q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(k))     val_q <= wr_data_i;
    end
    assign alarm_o[k*FIELD_W +: FIELD_W] = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      ctrl_o <= '0;
    end else if (wr_en_i) begin
      if (addr_i == MASK_ADDR) mask_o <= wr_data_i[NUM_FIELDS-1:0];
      if (addr_i == CTRL_ADDR) begin
        ctrl_o.irq_en   <= wr_data_i[CTRL_IEN_BIT];
        ctrl_o.auto_clr <= wr_data_i[CTRL_AUTO_BIT];
      end
    end
  end
endmodule

// File: rtl/alm_match.sv
module alm_match #(
  parameter int unsigned NUM_FIELDS = 6,
  parameter int unsigned FIELD_W    = 8
) (
  input  logic                          tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_i,
  input  logic [NUM_FIELDS-1:0]         mask_i,
  output logic                          hit_o
);
  logic [NUM_FIELDS-1:0] lane_ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_lane
    assign lane_ok[k] = !mask_i[k] ||
                        (time_i[k*FIELD_W +: FIELD_W] == alarm_i[k*FIELD_W +: FIELD_W]);
  end

  // empty mask must not match
  assign hit_o = tick_i && (|mask_i) && (&lane_ok);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r9_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_o);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 6,
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned ADDR_W     = $clog2(NUM_FIELDS + 3)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [FIELD_W-1:0]            wr_data_i,
  output logic                          status_o,
  output logic                          irq_oe_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_FIELDS + 2);

  logic [NUM_FIELDS*FIELD_W-1:0] alarm;
  logic [NUM_FIELDS-1:0]         mask;
  alm_ctrl_t                     ctrl;
  logic                          hit;
  logic                          stat_sel;
  logic                          clr;

  alm_regfile #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .alarm_o   (alarm),
    .mask_o    (mask),
    .ctrl_o    (ctrl)
  );

  alm_match #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_match (
    .tick_i  (tick_i),
    .time_i  (time_i),
    .alarm_i (alarm),
    .mask_i  (mask),
    .hit_o   (hit)
  );

  assign stat_sel = (addr_i == STAT_ADDR);
  assign clr = (wr_en_i && stat_sel && !wr_data_i[STAT_FLAG_BIT]) ||
               (rd_en_i && stat_sel && ctrl.auto_clr);

  alm_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr),
    .flag_o (status_o)
  );

  assign irq_oe_o = status_o && ctrl.irq_en;

  a_r3_no_tick_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o && !tick_i) |=> !status_o);
  a_r5_empty_mask_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o && mask == '0) |=> !status_o);
  a_r8_auto_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && stat_sel && ctrl.auto_clr && !hit) |=> !status_o);
  a_r8_plain_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && rd_en_i && !wr_en_i && !ctrl.auto_clr) |=> status_o);
endmodule

// File: tb/sim_alarm_irq_unit.sv
`timescale 1ns/1ps
module sim_alarm_irq_unit;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_MASK = 4'd6;
  localparam logic [AW-1:0] A_CTRL = 4'd7;
  localparam logic [AW-1:0] A_STAT = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NF*FW-1:0] tm = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [FW-1:0] wdata = '0;
  logic status, irq_oe;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  alarm_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tm),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata),
    .status_o(status), .irq_oe_o(irq_oe)
  );

  function automatic logic [FW-1:0] aval(int k);
    return FW'(8'h13 + 8'h21 * k);
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [FW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(logic [NF-1:0] eq);
    for (int k = 0; k < NF; k++)
      tm[k*FW +: FW] = eq[k] ? aval(k) : (aval(k) ^ 8'h5A);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    // R1 reset state
    chk("R1 status in reset", status, 1'b0);
    chk("R1 irq in reset", irq_oe, 1'b0);
    #10 rst_n = 1'b1;
    set_time('1);
    pulse_tick();
    chk("R1 mask zero after reset", status, 1'b0);

    // R2 program alarm fields
    for (int k = 0; k < NF; k++) wr(AW'(k), aval(k));

    // R4 R5 R6 sweep: every mask against every equality pattern
    for (int m = 0; m < (1 << NF); m++) begin
      for (int p = 0; p < (1 << NF); p++) begin
        logic ien, exp;
        ien = logic'(m[0] ^ p[1]);
        exp = (m != 0) && ((m & ~p & ((1 << NF) - 1)) == 0);
        wr(A_CTRL, {6'b0, 1'b0, ien});
        wr(A_MASK, FW'(m));
        set_time(NF'(p));
        pulse_tick();
        chk(m == 0 ? "R5 empty mask" : "R4 match", status, exp);
        chk("R6 irq gate", irq_oe, exp && ien);
        wr(A_STAT, 8'h00);
        chk("R7 clear by zero write", status, 1'b0);
      end
    end

    // R3 match with no tick
    wr(A_CTRL, 8'h01);
    wr(A_MASK, 8'h3F);
    set_time('1);
    repeat (5) @(negedge clk);
    chk("R3 no tick no set", status, 1'b0);
    pulse_tick();
    chk("R3 tick sets", status, 1'b1);
    chk("R6 irq on", irq_oe, 1'b1);

    // R7 writes that must not clear
    wr(A_STAT, 8'h01);
    chk("R7 write one keeps", status, 1'b1);
    wr(A_CTRL, 8'h01);
    chk("R7 other addr keeps", status, 1'b1);
    set_time('0);
    pulse_tick();
    chk("R7 non-match tick keeps", status, 1'b1);

    // R8 read without auto-clear
    rd(A_STAT);
    chk("R8 plain read keeps", status, 1'b1);
    wr(A_CTRL, 8'h03);
    rd(A_MASK);
    chk("R8 read other addr keeps", status, 1'b1);
    rd(A_STAT);
    chk("R8 auto read clears", status, 1'b0);
    chk("R8 irq released", irq_oe, 1'b0);

    // R9 match and clear in same cycle
    set_time('1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = A_STAT; wdata = 8'h00;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R9 set beats write clear", status, 1'b1);
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = A_STAT;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    chk("R9 set beats read clear", status, 1'b1);
    wr(A_STAT, 8'h00);
    chk("R7 final clear", status, 1'b0);

    // R2 single-field repeat: seconds only
    wr(A_MASK, 8'h01);
    set_time(6'b000001);
    pulse_tick();
    chk("R2 seconds-only repeat", status, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule